// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel Sequencer

This block is one DMA channel engine. A trigger starts a transaction. A transaction is a chain of blocks, and each block is described by a four-word descriptor held in memory. The engine reads the descriptor and then moves a fixed number of beats. Each beat is a read from a source address followed by a write of the same data to a destination address, at a width of 8, 16 or 32 bits. After each beat the engine updates the addresses and the remaining count. When a block ends, the engine either follows the descriptor's link to the next descriptor or closes the transaction.

Completion is reported on two pulse outputs. One pulses after each block whose descriptor asks for it. The other pulses once, at the end of the whole chain. A halt input stops the channel cleanly between beats, and no transaction-complete pulse follows a halted run. All traffic, descriptor reads included, goes through a single request/acknowledge memory port. Data travels in the low-order bits of the data buses, and a size code states how many bytes are valid.

Top module: `dma_chain_engine`

## Requirements
- R1: After reset, and whenever the channel is idle, `busy_o`, `mem_req_o`, `blk_done_o` and `xfer_done_o` are all low.
- R2: A high `trig_i` while idle and `halt_i` low starts a transaction. The engine reads four 32-bit words (size code 2) at `first_desc_i`, +4, +8 and +12. A trigger that arrives while the channel is busy is ignored.
- R3: Descriptor word 0 is the control word. Bits [1:0] hold the beat size (0 = 8-bit, 1 = 16-bit, 2 = 32-bit, and 3 is treated as 32-bit). Bit 2 enables source increment and bit 3 enables destination increment. Bit 4 enables the block-done pulse. Bits [31:16] hold the beat count. Words 1, 2 and 3 hold the source address, the destination address and the next-descriptor address.
- R4: Each beat is one read at the source address and then one write at the destination address. Both use the beat's size code on `mem_size_o`. The write data carries the bytes just read in its low-order bits, and the unused upper bits are zero.
- R5: After a beat, an address whose increment bit is set advances by 1, 2 or 4 bytes according to the beat size. An address whose increment bit is clear stays fixed.
- R6: A block performs exactly as many beats as its count field, and a count field of 0 means 65,536 beats.
- R7: At the end of a block, a nonzero next-descriptor address makes the engine fetch that descriptor and continue. A zero address ends the transaction.
- R8: `blk_done_o` pulses high for exactly one cycle after the last beat of each block whose block-done bit is set. It never pulses for a block whose bit is clear.
- R9: `xfer_done_o` pulses high for exactly one cycle after the last block of the chain, and `busy_o` is low in the following cycle.
- R10: A request stays asserted, with address, direction, size and write data unchanged, until `mem_ack_i` is high.
- R11: A high `halt_i` ends a busy channel after the beat in flight has been written. The channel returns to idle with no `xfer_done_o`. While `halt_i` is high, a trigger does not start the channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Start request from software or a peripheral |
| halt_i | input | 1 | Abort the channel at the next beat boundary |
| first_desc_i | input | ADDR_W | Address of the first descriptor of the chain |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | ADDR_W | Byte address of the access |
| mem_size_o | output | 2 | Access width: 0 byte, 1 half-word, 2 word |
| mem_wdata_o | output | 32 | Write data, in the low-order bits |
| mem_ack_i | input | 1 | Access accepted this cycle; read data valid |
| mem_rdata_i | input | 32 | Read data, in the low-order bits |
| busy_o | output | 1 | Channel is executing a transaction |
| blk_done_o | output | 1 | One-cycle pulse at block end (if enabled) |
| xfer_done_o | output | 1 | One-cycle pulse at transaction end |

## Verification
The bench builds the engine with its default 32-bit address width and the fixed 16-bit count field. It models memory as a 4 KiB byte array that aliases the upper address bits and acknowledges in the same cycle, so a beat takes two cycles. That speed brings the 65,536-beat block, selected by a count of 0, within the cycle budget. A pseudo-random grant mode stalls the port during a three-block chain to exercise request holding. Short single-block runs with logged addresses check every size and increment combination against a byte-level model kept inside the bench.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

  localparam int DESC_WORDS  = 4;
  localparam int CNT_FIELD_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_READ,
    ST_WRITE,
    ST_NEXT,
    ST_DONE
  } dmac_state_e;

  typedef struct packed {
    logic [CNT_FIELD_W-1:0] count;
    logic                   blk_irq;
    logic                   dst_inc;
    logic                   src_inc;
    logic [1:0]             bsize;
  } dmac_ctrl_t;

  // control word: [31:16] count, [4] block pulse, [3] dst inc, [2] src inc, [1:0] size
  function automatic dmac_ctrl_t decode_ctrl(input logic [31:0] w);
    dmac_ctrl_t r;
    r.count   = w[31:16];
    r.blk_irq = w[4];
    r.dst_inc = w[3];
    r.src_inc = w[2];
    r.bsize   = (w[1:0] == 2'd3) ? 2'd2 : w[1:0];
    return r;
  endfunction

  function automatic logic [2:0] beat_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [31:0] lane_keep(input logic [1:0] sz, input logic [31:0] d);
    case (sz)
      2'd0:    return {24'h0, d[7:0]};
      2'd1:    return {16'h0, d[15:0]};
      default: return d;
    endcase
  endfunction

endpackage

// File: rtl/dmac_desc_store.sv
module dmac_desc_store
  import dmac_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORDS  = DESC_WORDS
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cap_en,
  input  logic [$clog2(WORDS)-1:0] cap_idx,
  input  logic [31:0]              cap_word,
  output dmac_ctrl_t               ctrl_o,
  output logic [ADDR_W-1:0]        src_o,
  output logic [ADDR_W-1:0]        dst_o,
  output logic [ADDR_W-1:0]        next_o
);
  localparam int IDX_W = $clog2(WORDS);

  logic [31:0] word_q [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q[g] <= '0;
      end else if (cap_en && (cap_idx == IDX_W'(g))) begin
        word_q[g] <= cap_word;
      end
    end
  end

  assign ctrl_o = decode_ctrl(word_q[0]);
  assign src_o  = word_q[1][ADDR_W-1:0];
  assign dst_o  = word_q[2][ADDR_W-1:0];
  assign next_o = word_q[3][ADDR_W-1:0];

endmodule

// File: rtl/dmac_addr_unit.sv
module dmac_addr_unit #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step_en,
  input  logic              inc_en,
  input  logic [2:0]        step_bytes,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_d;
  logic              addr_en;

  always_comb begin
    addr_en = load_en || (step_en && inc_en);
    addr_d  = load_en ? load_val : (addr_q + ADDR_W'(step_bytes));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= addr_d;
    end
  end

  assign addr_o = addr_q;

endmodule

// File: rtl/dmac_beat_counter.sv
module dmac_beat_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec_en,
  output logic             last_o
);
  localparam int REM_W = CNT_W + 1;

  logic [REM_W-1:0] rem_q;
  logic [REM_W-1:0] rem_d;

  always_comb begin
    if (load_en) begin
      rem_d = (load_val == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, load_val};
    end else begin
      rem_d = rem_q - REM_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
    end else if (load_en || dec_en) begin
      rem_q <= rem_d;
    end
  end

  assign last_o = (rem_q == REM_W'(1));

endmodule

// File: rtl/dma_chain_engine.sv
module dma_chain_engine
  import dmac_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_i,
  input  logic              halt_i,
  input  logic [ADDR_W-1:0] first_desc_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [1:0]        mem_size_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              busy_o,
  output logic              blk_done_o,
  output logic              xfer_done_o
);
  localparam int IDX_W = $clog2(DESC_WORDS);
  localparam int CNT_W = CNT_FIELD_W;

  dmac_state_e       state_q, state_d;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] desc_ptr_q;
  logic [31:0]       data_q;
  logic              abort_q;

  logic cap_en, blk_load, beat_step, data_en;
  logic ptr_first, ptr_next, idx_clr, idx_inc;
  logic abort_now, last_beat;

  dmac_ctrl_t        ctrl;
  logic [ADDR_W-1:0] src_init, dst_init, next_ptr;
  logic [ADDR_W-1:0] src_addr, dst_addr;
  logic [2:0]        step;

  dmac_desc_store #(.ADDR_W(ADDR_W), .WORDS(DESC_WORDS)) u_desc (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (cap_en),
    .cap_idx  (idx_q),
    .cap_word (mem_rdata_i),
    .ctrl_o   (ctrl),
    .src_o    (src_init),
    .dst_o    (dst_init),
    .next_o   (next_ptr)
  );

  assign step = beat_bytes(ctrl.bsize);

  dmac_addr_unit #(.ADDR_W(ADDR_W)) u_src (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_en    (blk_load),
    .load_val   (src_init),
    .step_en    (beat_step),
    .inc_en     (ctrl.src_inc),
    .step_bytes (step),
    .addr_o     (src_addr)
  );

  dmac_addr_unit #(.ADDR_W(ADDR_W)) u_dst (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_en    (blk_load),
    .load_val   (dst_init),
    .step_en    (beat_step),
    .inc_en     (ctrl.dst_inc),
    .step_bytes (step),
    .addr_o     (dst_addr)
  );

  dmac_beat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (blk_load),
    .load_val (ctrl.count),
    .dec_en   (beat_step),
    .last_o   (last_beat)
  );

  assign abort_now = abort_q || halt_i;

  // next-state logic
  always_comb begin
    state_d   = state_q;
    cap_en    = 1'b0;
    blk_load  = 1'b0;
    beat_step = 1'b0;
    data_en   = 1'b0;
    ptr_first = 1'b0;
    ptr_next  = 1'b0;
    idx_clr   = 1'b0;
    idx_inc   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (trig_i && !halt_i) begin
          state_d   = ST_FETCH;
          ptr_first = 1'b1;
          idx_clr   = 1'b1;
        end
      end
      ST_FETCH: begin
        if (mem_ack_i) begin
          cap_en = 1'b1;
          if (idx_q == IDX_W'(DESC_WORDS - 1)) begin
            state_d  = ST_READ;
            blk_load = 1'b1;
          end else begin
            idx_inc = 1'b1;
          end
        end
      end
      ST_READ: begin
        if (mem_ack_i) begin
          data_en = 1'b1;
          state_d = ST_WRITE;
        end
      end
      ST_WRITE: begin
        if (mem_ack_i) begin
          beat_step = 1'b1;
          if (abort_now)      state_d = ST_IDLE;
          else if (last_beat) state_d = ST_NEXT;
          else                state_d = ST_READ;
        end
      end
      ST_NEXT: begin
        if (abort_now) begin
          state_d = ST_IDLE;
        end else if (next_ptr == '0) begin
          state_d = ST_DONE;
        end else begin
          state_d  = ST_FETCH;
          ptr_next = 1'b1;
          idx_clr  = 1'b1;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_clr) begin
      idx_q <= '0;
    end else if (idx_inc) begin
      idx_q <= idx_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      desc_ptr_q <= '0;
    end else if (ptr_first) begin
      desc_ptr_q <= first_desc_i;
    end else if (ptr_next) begin
      desc_ptr_q <= next_ptr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (data_en) begin
      data_q <= lane_keep(ctrl.bsize, mem_rdata_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      abort_q <= 1'b0;
    end else if (state_q == ST_IDLE) begin
      abort_q <= 1'b0;
    end else if (halt_i) begin
      abort_q <= 1'b1;
    end
  end

  // outputs
  always_comb begin
    mem_req_o   = (state_q == ST_FETCH) || (state_q == ST_READ) || (state_q == ST_WRITE);
    mem_we_o    = (state_q == ST_WRITE);
    mem_size_o  = (state_q == ST_FETCH) ? 2'd2 : ctrl.bsize;
    mem_wdata_o = (state_q == ST_WRITE) ? data_q : 32'h0;
    case (state_q)
      ST_FETCH: mem_addr_o = desc_ptr_q + ADDR_W'({idx_q, 2'b00});
      ST_WRITE: mem_addr_o = dst_addr;
      default:  mem_addr_o = src_addr;
    endcase
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign blk_done_o  = (state_q == ST_NEXT) && ctrl.blk_irq;
  assign xfer_done_o = (state_q == ST_DONE);

endmodule

// File: rtl/dma_chain_engine_chk.sv
module dma_chain_engine_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              halt_i,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [1:0]        mem_size_o,
  input logic [31:0]       mem_wdata_o,
  input logic              mem_ack_i,
  input logic              busy_o,
  input logic              blk_done_o,
  input logic              xfer_done_o
);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!mem_req_o && !blk_done_o && !xfer_done_o));

  a_r10_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)
                                   && $stable(mem_size_o) && $stable(mem_wdata_o)));

  a_r4_legal_size: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> (mem_size_o != 2'd3));

  a_r4_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_we_o && mem_size_o == 2'd0) |-> (mem_wdata_o[31:8] == 24'h0));

  a_r4_half_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_we_o && mem_size_o == 2'd1) |-> (mem_wdata_o[31:16] == 16'h0));

  a_r8_blk_single: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done_o |=> !blk_done_o);

  a_r9_xfer_single: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done_o |=> (!xfer_done_o && !busy_o));

  a_r11_halt_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_i && !busy_o) |=> !busy_o);

endmodule

bind dma_chain_engine dma_chain_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .halt_i      (halt_i),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_size_o  (mem_size_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_ack_i   (mem_ack_i),
  .busy_o      (busy_o),
  .blk_done_o  (blk_done_o),
  .xfer_done_o (xfer_done_o)
);

// File: tb/dma_chain_engine_test.sv
`timescale 1ns/1ps
module dma_chain_engine_test;
  localparam int ADDR_W = 32;
  localparam int MEMSZ  = 4096;
  localparam int LOGSZ  = 1024;

  typedef struct packed {
    logic [1:0]  bsz;
    logic        si;
    logic        di;
    logic        irq;
    logic [15:0] cnt;
    logic [11:0] src;
    logic [11:0] dst;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b1, 1'b1, 1'b1, 16'd5, 12'h100, 12'h800},
    '{2'd1, 1'b1, 1'b1, 1'b0, 16'd7, 12'h140, 12'h900},
    '{2'd2, 1'b1, 1'b1, 1'b1, 16'd9, 12'h180, 12'hA00},
    '{2'd2, 1'b1, 1'b0, 1'b0, 16'd4, 12'h200, 12'hB00},
    '{2'd1, 1'b0, 1'b1, 1'b1, 16'd6, 12'h240, 12'hB40},
    '{2'd0, 1'b1, 1'b1, 1'b1, 16'd1, 12'h280, 12'hC00},
    '{2'd3, 1'b1, 1'b1, 1'b0, 16'd3, 12'h2C0, 12'hC40}
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic              trig, halt;
  logic [ADDR_W-1:0] first_desc;
  logic              mem_req, mem_we, mem_ack;
  logic [ADDR_W-1:0] mem_addr;
  logic [1:0]        mem_size;
  logic [31:0]       mem_wdata, mem_rdata;
  logic              busy, blk_done, xfer_done;

  always #2 clk = ~clk;

  dma_chain_engine #(.ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .halt_i(halt), .first_desc_i(first_desc),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_size_o(mem_size),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .busy_o(busy), .blk_done_o(blk_done), .xfer_done_o(xfer_done)
  );

  logic [7:0]  mem    [MEMSZ];
  logic [7:0]  shadow [MEMSZ];
  logic [31:0] rd_log [LOGSZ];
  logic [1:0]  rd_sz  [LOGSZ];
  logic [31:0] wr_log [LOGSZ];
  int n_rd = 0, n_wr = 0, n_blk = 0, n_xfer = 0;
  int total = 0, bad = 0;
  logic        stall_mode = 1'b0, gnt_ok;
  logic [15:0] lfsr;

  function automatic int mi(input logic [31:0] a);
    return int'(a[11:0]);
  endfunction

  function automatic int wbytes(input logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
  endfunction

  assign mem_ack   = mem_req && gnt_ok;
  assign mem_rdata = {mem[mi(mem_addr + 32'd3)], mem[mi(mem_addr + 32'd2)],
                      mem[mi(mem_addr + 32'd1)], mem[mi(mem_addr)]};

  always @(posedge clk) begin
    if (!rst_n) begin
      lfsr   <= 16'hACE1;
      gnt_ok <= 1'b1;
    end else begin
      lfsr   <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      gnt_ok <= stall_mode ? lfsr[0] : 1'b1;
      if (mem_req && mem_ack) begin
        if (mem_we) begin
          for (int b = 0; b < wbytes(mem_size); b++)
            mem[mi(mem_addr + 32'(b))] <= mem_wdata[8*b +: 8];
          if (n_wr < LOGSZ) wr_log[n_wr] <= mem_addr;
          n_wr <= n_wr + 1;
        end else begin
          if (n_rd < LOGSZ) begin
            rd_log[n_rd] <= mem_addr;
            rd_sz[n_rd]  <= mem_size;
          end
          n_rd <= n_rd + 1;
        end
      end
      if (blk_done)  n_blk  <= n_blk + 1;
      if (xfer_done) n_xfer <= n_xfer + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic put_word(input int a, input logic [31:0] w);
    for (int b = 0; b < 4; b++) begin
      mem[(a + b) % MEMSZ]    = w[8*b +: 8];
      shadow[(a + b) % MEMSZ] = w[8*b +: 8];
    end
  endtask

  task automatic put_desc(input int at, input logic [1:0] bsz, input bit si, input bit di,
                          input bit irq, input int cnt, input int src, input int dst,
                          input int nxt);
    put_word(at,      {cnt[15:0], 11'h0, irq, di, si, bsz});
    put_word(at + 4,  32'(src));
    put_word(at + 8,  32'(dst));
    put_word(at + 12, 32'(nxt));
  endtask

  task automatic model_block(input logic [1:0] bsz, input bit si, input bit di,
                             input int n, input int src, input int dst);
    int w = wbytes(bsz);
    int s = src;
    int d = dst;
    logic [7:0] t [4];
    for (int i = 0; i < n; i++) begin
      for (int b = 0; b < w; b++) t[b] = shadow[(s + b) % MEMSZ];
      for (int b = 0; b < w; b++) shadow[(d + b) % MEMSZ] = t[b];
      if (si) s += w;
      if (di) d += w;
    end
  endtask

  task automatic cmp_mem(input string tag);
    int mism = 0;
    for (int i = 0; i < MEMSZ; i++) if (mem[i] !== shadow[i]) mism++;
    chk(mism == 0, tag, "memory bytes differing from model", mism, 0);
  endtask

  task automatic start(input int desc);
    @(negedge clk);
    first_desc = 32'(desc);
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
  endtask

  task automatic wait_idle(input int limit);
    int k = 0;
    while (busy && k < limit) begin
      @(negedge clk);
      k++;
    end
    chk(!busy, "R9", "channel returned to idle", busy, 0);
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int r0, w0, b0, x0, wd;
    for (int i = 0; i < MEMSZ; i++) begin
      mem[i]    = 8'(i * 37 + 11);
      shadow[i] = 8'(i * 37 + 11);
    end
    rst_n = 1'b0; trig = 1'b0; halt = 1'b0; first_desc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0,      "R1", "busy after reset", busy, 0);
    chk(mem_req == 1'b0,   "R1", "req after reset", mem_req, 0);
    chk(blk_done == 1'b0,  "R1", "blk pulse after reset", blk_done, 0);
    chk(xfer_done == 1'b0, "R1", "xfer pulse after reset", xfer_done, 0);

    // table-driven single-block transactions (R3 field layout, R4 data, R5 addresses)
    for (int v = 0; v < NV; v++) begin
      int w;
      w = wbytes(VECS[v].bsz);
      put_desc(0, VECS[v].bsz, VECS[v].si, VECS[v].di, VECS[v].irq,
               int'(VECS[v].cnt), int'(VECS[v].src), int'(VECS[v].dst), 0);
      r0 = n_rd; w0 = n_wr; b0 = n_blk; x0 = n_xfer;
      start(0);
      wait_idle(1000);
      model_block(VECS[v].bsz, VECS[v].si, VECS[v].di, int'(VECS[v].cnt),
                  int'(VECS[v].src), int'(VECS[v].dst));
      chk(n_xfer - x0 == 1, "R9", "transaction pulses", n_xfer - x0, 1);
      chk(n_blk - b0 == int'(VECS[v].irq), "R8", "block pulses", n_blk - b0, VECS[v].irq);
      chk(n_wr - w0 == int'(VECS[v].cnt), "R6", "beats written", n_wr - w0, VECS[v].cnt);
      for (int k = 0; k < 4; k++) begin
        chk(rd_log[r0 + k] == 32'(4 * k), "R2", "descriptor word address",
            rd_log[r0 + k], 4 * k);
        chk(rd_sz[r0 + k] == 2'd2, "R2", "descriptor read size", rd_sz[r0 + k], 2);
      end
      for (int i = 0; i < int'(VECS[v].cnt); i++) begin
        chk(rd_log[r0 + 4 + i] == 32'(int'(VECS[v].src) + (VECS[v].si ? i * w : 0)),
            "R5", "source address", rd_log[r0 + 4 + i],
            int'(VECS[v].src) + (VECS[v].si ? i * w : 0));
        chk(wr_log[w0 + i] == 32'(int'(VECS[v].dst) + (VECS[v].di ? i * w : 0)),
            "R5", "destination address", wr_log[w0 + i],
            int'(VECS[v].dst) + (VECS[v].di ? i * w : 0));
      end
      cmp_mem("R3 R4");
    end

    // R7 three-block chain under a stalling memory port (R10)
    put_desc(16, 2'd2, 1'b1, 1'b1, 1'b1, 3, 'h300, 'hD00, 32);
    put_desc(32, 2'd0, 1'b1, 1'b1, 1'b0, 5, 'h340, 'hD40, 48);
    put_desc(48, 2'd1, 1'b1, 1'b1, 1'b1, 4, 'h380, 'hD80, 0);
    stall_mode = 1'b1;
    r0 = n_rd; w0 = n_wr; b0 = n_blk; x0 = n_xfer;
    start(16);
    wait_idle(2000);
    stall_mode = 1'b0;
    model_block(2'd2, 1'b1, 1'b1, 3, 'h300, 'hD00);
    model_block(2'd0, 1'b1, 1'b1, 5, 'h340, 'hD40);
    model_block(2'd1, 1'b1, 1'b1, 4, 'h380, 'hD80);
    chk(n_xfer - x0 == 1, "R7", "chain transaction pulses", n_xfer - x0, 1);
    chk(n_blk - b0 == 2, "R8", "chain block pulses", n_blk - b0, 2);
    chk(n_wr - w0 == 12, "R7", "chain beats", n_wr - w0, 12);
    chk(n_rd - r0 == 24, "R7", "chain reads", n_rd - r0, 24);
    chk(rd_log[r0 + 7] == 32'd32, "R7", "second descriptor address", rd_log[r0 + 7], 32);
    chk(rd_log[r0 + 16] == 32'd48, "R7", "third descriptor address", rd_log[r0 + 16], 48);
    cmp_mem("R10 R7");

    // R2 retrigger while busy is ignored
    put_desc(0, 2'd0, 1'b1, 1'b1, 1'b0, 8, 'h600, 'h680, 0);
    r0 = n_rd; w0 = n_wr; x0 = n_xfer;
    start(0);
    first_desc = 32'd16;
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    wait_idle(1000);
    model_block(2'd0, 1'b1, 1'b1, 8, 'h600, 'h680);
    chk(n_xfer - x0 == 1, "R2", "retrigger transactions", n_xfer - x0, 1);
    chk(n_wr - w0 == 8, "R2", "retrigger beats", n_wr - w0, 8);
    chk(n_rd - r0 == 12, "R2", "retrigger reads", n_rd - r0, 12);
    cmp_mem("R2");

    // R11 halt mid-block
    put_desc(0, 2'd0, 1'b1, 1'b1, 1'b1, 200, 'h400, 'hE00, 0);
    r0 = n_rd; w0 = n_wr; b0 = n_blk; x0 = n_xfer;
    start(0);
    repeat (40) @(negedge clk);
    halt = 1'b1;
    @(negedge clk);
    halt = 1'b0;
    wait_idle(1000);
    wd = n_wr - w0;
    model_block(2'd0, 1'b1, 1'b1, wd, 'h400, 'hE00);
    chk(n_xfer - x0 == 0, "R11", "transaction pulse after halt", n_xfer - x0, 0);
    chk(n_blk - b0 == 0, "R11", "block pulse after halt", n_blk - b0, 0);
    chk(wd > 0 && wd < 200, "R11", "beats before halt", wd, 100);
    chk(n_rd - r0 == wd + 4, "R11", "reads vs writes at halt", n_rd - r0, wd + 4);
    cmp_mem("R11");
    halt = 1'b1;
    r0 = n_rd;
    start(0);
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R11", "busy with halt held", busy, 0);
    chk(n_rd - r0 == 0, "R11", "reads with halt held", n_rd - r0, 0);
    halt = 1'b0;

    // R6 count field 0 gives 65536 beats
    put_desc(0, 2'd0, 1'b0, 1'b0, 1'b1, 0, 'h500, 'hF00, 0);
    w0 = n_wr; b0 = n_blk; x0 = n_xfer;
    start(0);
    wait_idle(140000);
    model_block(2'd0, 1'b0, 1'b0, 65536, 'h500, 'hF00);
    chk(n_wr - w0 == 65536, "R6", "beats for count 0", n_wr - w0, 65536);
    chk(n_blk - b0 == 1, "R8", "block pulse for count 0", n_blk - b0, 1);
    chk(n_xfer - x0 == 1, "R9", "transaction pulse for count 0", n_xfer - x0, 1);
    cmp_mem("R6");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule